// File: doc/BRIEF.md
# UART interrupt status and mask logic

This block holds the interrupt side of a memory-mapped serial port. It does not contain the FIFOs or the shifters. It takes the receive and transmit FIFO fill counts as inputs, along with single-cycle pulses that report receive overrun, framing error, parity error, receive timeout, modem status change and transmit overflow. From the counts it forms a live status word. From that word and the pulses it keeps a sticky interrupt status register. The status word reports empty, full and at-or-above-threshold for each direction, using two programmable trigger levels.

Software enables interrupt sources by writing to one address and disables them by writing to another. The mask itself cannot be written directly. Pending sources are cleared by writing ones to the interrupt status register. A single level output goes high while any pending source is also enabled. All registers sit behind a plain word-addressed read/write port. Reads are combinational and writes take effect at the clock edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask (word 2) and the interrupt status (word 3) read 0, the RX trigger level (word 5) and the TX trigger level (word 6) both read 32, and `irq` is 0.
- R2: A write to word 0 ORs the written value into the mask, keeping only the implemented bits 0..10 and 12. A write to word 1 clears every mask bit written as 1. A write to word 2 leaves the mask unchanged.
- R3: The status word (word 4) is live and is built from the counts and trigger levels of the current cycle, as follows:
  - bit 0 = RX count ≥ RX trigger level
  - bit 1 = RX count is 0
  - bit 2 = RX count equals RX_DEPTH
  - bit 3 = TX count is 0
  - bit 4 = TX count equals TX_DEPTH
- R4: Status bit 13 is set while TX count ≥ TX trigger level. Its interrupt status counterpart is bit 10.
- R5: At each clock edge, status bits 4..0 are ORed into interrupt status bits 4..0, and status bit 13 sets interrupt status bit 10. These bits stay set after the condition goes away.
- R6: Writing word 3 clears each interrupt status bit written as 1. Bits written as 0 are kept.
- R7: Each event pulse sets its interrupt status bit at the next edge, as follows:
  - overrun sets bit 5
  - framing sets bit 6
  - parity sets bit 7
  - timeout sets bit 8
  - modem sets bit 9
  - TX overflow sets bit 12
- R8: `irq` is 1 exactly when the AND of mask and interrupt status is non-zero. It follows the registers with no extra delay.
- R9: When a set source (level or event) and a clearing write hit the same interrupt status bit in the same cycle, the bit ends up set.
- R10: Words 5 and 6 are writable trigger levels. Words 4 and 7 and above ignore writes. Words 7 and above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count | input | CNT_W | Receive FIFO fill level |
| tx_count | input | CNT_W | Transmit FIFO fill level |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_overflow | input | 1 | Transmit overflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with RX_DEPTH = 48 and TX_DEPTH = 40, which gives a 6-bit count. With unequal depths, a full flag tied to the wrong direction shows up, and both full thresholds lie above the reset trigger level of 32. This means a full FIFO also raises the threshold bits, and the trigger width is exactly the minimum that holds 32. Lowering and raising the TX trigger around a fixed count checks the threshold comparison from both sides.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int IRQ_W  = 13;
   localparam int STAT_W = 14;

   localparam int B_RX_TRIG   = 0;
   localparam int B_RX_EMPTY  = 1;
   localparam int B_RX_FULL   = 2;
   localparam int B_TX_EMPTY  = 3;
   localparam int B_TX_FULL   = 4;
   localparam int B_OVERRUN   = 5;
   localparam int B_FRAME     = 6;
   localparam int B_PARITY    = 7;
   localparam int B_TIMEOUT   = 8;
   localparam int B_MODEM     = 9;
   localparam int B_TX_TRIG_I = 10;
   localparam int B_TX_OVF    = 12;
   localparam int B_TX_TRIG_S = 13;

   localparam logic [IRQ_W-1:0] IRQ_IMPL = 13'h17FF;

   typedef enum logic [2:0] {
      A_IEN    = 3'd0,
      A_IDIS   = 3'd1,
      A_MASK   = 3'd2,
      A_ISR    = 3'd3,
      A_STAT   = 3'd4,
      A_RXTRIG = 3'd5,
      A_TXTRIG = 3'd6
   } reg_word_e;

   localparam int NUM_REGS = 7;
endpackage

// File: rtl/uart_irq_lvl.sv
module uart_irq_lvl #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 7
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] trig,
   output logic             at_trig,
   output logic             empty,
   output logic             full
);
   assign at_trig = (count >= trig);
   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
   parameter int               W    = 13,
   parameter logic [W-1:0]     IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wval,
   output logic [W-1:0] mask
);
   always_ff @(posedge clk) begin
      if (!rst_n)      mask <= '0;
      else if (set_we) mask <= (mask | wval) & IMPL;
      else if (clr_we) mask <= mask & ~wval;
   end

   // R2
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_we || clr_we) |=> $stable(mask));

   // R2
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((mask & $past(wval & IMPL)) == $past(wval & IMPL)));
endmodule

// File: rtl/uart_irq_isr.sv
module uart_irq_isr #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         clr_we,
   input  logic [W-1:0] clr_val,
   output logic [W-1:0] isr
);
   logic [W-1:0] clr_bits;
   assign clr_bits = clr_we ? clr_val : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) isr <= '0;
      else        isr <= (isr & ~clr_bits) | set_vec;
   end

   // R5
   isr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(isr) & ~$past(clr_bits)) & ~isr) == '0));

   // R9
   isr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((isr & $past(set_vec)) == $past(set_vec)));

   // R6
   isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((isr & $past(clr_val & ~set_vec)) == '0));
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 7,
   parameter int TRIG_RST = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [IRQ_W-1:0]  mask,
   input  logic [IRQ_W-1:0]  isr,
   input  logic [STAT_W-1:0] status,
   output logic              ien_we,
   output logic              idis_we,
   output logic              isr_we,
   output logic [CNT_W-1:0]  rx_trig,
   output logic [CNT_W-1:0]  tx_trig,
   output logic [DATA_W-1:0] reg_rdata
);
   logic      in_range;
   reg_word_e word;
   logic      unused_wdata;

   assign in_range     = (reg_addr < ADDR_W'(NUM_REGS));
   assign word         = reg_word_e'(reg_addr[2:0]);
   assign unused_wdata = ^reg_wdata[DATA_W-1:IRQ_W];

   assign ien_we  = reg_wr && in_range && (word == A_IEN);
   assign idis_we = reg_wr && in_range && (word == A_IDIS);
   assign isr_we  = reg_wr && in_range && (word == A_ISR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_trig <= CNT_W'(TRIG_RST);
         tx_trig <= CNT_W'(TRIG_RST);
      end else if (reg_wr && in_range) begin
         if (word == A_RXTRIG) rx_trig <= reg_wdata[CNT_W-1:0];
         if (word == A_TXTRIG) tx_trig <= reg_wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (in_range) begin
         case (word)
            A_MASK:   reg_rdata = DATA_W'(mask);
            A_ISR:    reg_rdata = DATA_W'(isr);
            A_STAT:   reg_rdata = DATA_W'(status);
            A_RXTRIG: reg_rdata = DATA_W'(rx_trig);
            A_TXTRIG: reg_rdata = DATA_W'(tx_trig);
            default:  reg_rdata = '0;
         endcase
      end
   end

   // R10
   trig_oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !in_range) |=> ($stable(rx_trig) && $stable(tx_trig)));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int RX_DEPTH  = 64,
   parameter int TX_DEPTH  = 64,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int TRIG_RST  = 32,
   localparam int MAX_DEPTH = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
   localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic              ev_rx_overrun,
   input  logic              ev_frame_err,
   input  logic              ev_parity_err,
   input  logic              ev_rx_timeout,
   input  logic              ev_modem,
   input  logic              ev_tx_overflow,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   initial begin
      elab_data_w_chk: assert (DATA_W >= STAT_W)
         else $error("DATA_W too narrow for status word");
      elab_addr_w_chk: assert (ADDR_W >= 3)
         else $error("ADDR_W too narrow for register map");
      elab_trig_chk: assert (TRIG_RST < (1 << CNT_W))
         else $error("TRIG_RST does not fit count width");
      elab_cnt_chk: assert (CNT_W <= IRQ_W)
         else $error("depth too large for write data layout");
   end

   logic [CNT_W-1:0]  cnt     [2];
   logic [CNT_W-1:0]  trig    [2];
   logic [1:0]        at_trig;
   logic [1:0]        empty;
   logic [1:0]        full;
   logic [STAT_W-1:0] status;
   logic [IRQ_W-1:0]  set_vec;
   logic [IRQ_W-1:0]  mask;
   logic [IRQ_W-1:0]  isr;
   logic              ien_we;
   logic              idis_we;
   logic              isr_we;
   logic [CNT_W-1:0]  rx_trig;
   logic [CNT_W-1:0]  tx_trig;

   assign cnt[0]  = rx_count;
   assign cnt[1]  = tx_count;
   assign trig[0] = rx_trig;
   assign trig[1] = tx_trig;

   for (genvar d = 0; d < 2; d++) begin : g_dir
      localparam int DEPTH = (d == 0) ? RX_DEPTH : TX_DEPTH;
      uart_irq_lvl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lvl (
         .count   (cnt[d]),
         .trig    (trig[d]),
         .at_trig (at_trig[d]),
         .empty   (empty[d]),
         .full    (full[d])
      );
   end

   always_comb begin
      status                = '0;
      status[B_RX_TRIG]     = at_trig[0];
      status[B_RX_EMPTY]    = empty[0];
      status[B_RX_FULL]     = full[0];
      status[B_TX_EMPTY]    = empty[1];
      status[B_TX_FULL]     = full[1];
      status[B_TX_TRIG_S]   = at_trig[1];
   end

   always_comb begin
      set_vec              = '0;
      set_vec[4:0]         = status[4:0];
      set_vec[B_TX_TRIG_I] = status[B_TX_TRIG_S];
      set_vec[B_OVERRUN]   = ev_rx_overrun;
      set_vec[B_FRAME]     = ev_frame_err;
      set_vec[B_PARITY]    = ev_parity_err;
      set_vec[B_TIMEOUT]   = ev_rx_timeout;
      set_vec[B_MODEM]     = ev_modem;
      set_vec[B_TX_OVF]    = ev_tx_overflow;
   end

   uart_irq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TRIG_RST(TRIG_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .mask      (mask),
      .isr       (isr),
      .status    (status),
      .ien_we    (ien_we),
      .idis_we   (idis_we),
      .isr_we    (isr_we),
      .rx_trig   (rx_trig),
      .tx_trig   (tx_trig),
      .reg_rdata (reg_rdata)
   );

   uart_irq_mask #(.W(IRQ_W), .IMPL(IRQ_IMPL)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (ien_we),
      .clr_we (idis_we),
      .wval   (reg_wdata[IRQ_W-1:0]),
      .mask   (mask)
   );

   uart_irq_isr #(.W(IRQ_W)) u_isr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_we  (isr_we),
      .clr_val (reg_wdata[IRQ_W-1:0]),
      .isr     (isr)
   );

   assign irq = |(mask & isr);

   // R4
   tx_trig_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_TX_TRIG_S] |=> isr[B_TX_TRIG_I]);

   // R5
   rx_empty_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_RX_EMPTY] |=> isr[B_RX_EMPTY]);
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
   localparam int RXD   = 48;
   localparam int TXD   = 40;
   localparam int CNT_W = 6;
   localparam int IMPL  = 'h17FF;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] rx_count = 6'd5;
   logic [CNT_W-1:0] tx_count = 6'd5;
   logic             ev_rx_overrun = 1'b0, ev_frame_err = 1'b0, ev_parity_err = 1'b0;
   logic             ev_rx_timeout = 1'b0, ev_modem = 1'b0, ev_tx_overflow = 1'b0;
   logic             reg_wr = 1'b0;
   logic [3:0]       reg_addr = 4'd0;
   logic [31:0]      reg_wdata = 32'd0;
   logic [31:0]      reg_rdata;
   logic             irq;

   int checks = 0;
   int errors = 0;
   int mmask = 0, misr = 0, mrxt = 32, mtxt = 32;

   always #5 clk = ~clk;

   uart_irq_ctrl #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_uart_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
      .ev_rx_overrun(ev_rx_overrun), .ev_frame_err(ev_frame_err),
      .ev_parity_err(ev_parity_err), .ev_rx_timeout(ev_rx_timeout),
      .ev_modem(ev_modem), .ev_tx_overflow(ev_tx_overflow),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(string req, int got, int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   function automatic int mstat();
      int s = 0;
      int rc = int'(rx_count);
      int tc = int'(tx_count);
      if (rc >= mrxt) s |= 1;
      if (rc == 0)    s |= 2;
      if (rc == RXD)  s |= 4;
      if (tc == 0)    s |= 8;
      if (tc == TXD)  s |= 16;
      if (tc >= mtxt) s |= 'h2000;
      return s;
   endfunction

   // one clock of the reference model, then irq compared (R8)
   task automatic tick();
      int st  = mstat();
      int set = (st & 31) | (((st >> 13) & 1) << 10);
      int clr = 0;
      int w   = int'(reg_wdata);
      if (ev_rx_overrun)  set |= 1 << 5;
      if (ev_frame_err)   set |= 1 << 6;
      if (ev_parity_err)  set |= 1 << 7;
      if (ev_rx_timeout)  set |= 1 << 8;
      if (ev_modem)       set |= 1 << 9;
      if (ev_tx_overflow) set |= 1 << 12;
      if (reg_wr) begin
         case (int'(reg_addr))
            0: mmask = (mmask | w) & IMPL;
            1: mmask = mmask & ~w & 'h1FFF;
            3: clr = w & 'h1FFF;
            5: mrxt = w & 63;
            6: mtxt = w & 63;
            default: ;
         endcase
      end
      misr = ((misr & ~clr) | set) & 'h1FFF;
      @(posedge clk);
      #1;
      check("R8 irq", int'(irq), ((mmask & misr) != 0) ? 1 : 0);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr = 1'b0; reg_wdata = 32'd0;
   endtask

   task automatic rd(input logic [3:0] a, int exp, string req);
      reg_addr = a;
      #1;
      check(req, int'(reg_rdata), exp);
   endtask

   task automatic clear_events();
      ev_rx_overrun = 0; ev_frame_err = 0; ev_parity_err = 0;
      ev_rx_timeout = 0; ev_modem = 0; ev_tx_overflow = 0;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(2, 0, "R1 mask");
      rd(3, 0, "R1 isr");
      rd(5, 32, "R1 rx trig");
      rd(6, 32, "R1 tx trig");
      check("R1 irq", int'(irq), 0);
      repeat (3) tick();
      rd(3, 0, "R5 no level set");

      // R2 mask enable/disable/direct
      wr(0, 32'h3);          rd(2, 3, "R2 enable");
      wr(1, 32'h1);          rd(2, 2, "R2 disable");
      wr(2, 32'h1FFF);       rd(2, 2, "R2 direct ignored");
      wr(0, 32'hFFFF_FFFF);  rd(2, 'h17FF, "R2 implemented bits");
      wr(1, 32'h17FD);       rd(2, 2, "R2 disable many");

      // R3 / R5 / R6 rx empty
      rx_count = 6'd0;
      rd(4, 'h2, "R3 rx empty");
      tick();
      rd(3, 'h2, "R5 copy");
      check("R8 irq high", int'(irq), 1);
      rx_count = 6'd5;
      tick(); tick();
      rd(3, 'h2, "R5 sticky");
      wr(3, 32'h2);
      rd(3, 0, "R6 clear");

      // R3 / R4 full and thresholds
      rx_count = 6'd48;
      rd(4, 'h5, "R3 rx full and trig");
      tick();
      rd(3, 'h5, "R5 rx full copy");
      tx_count = 6'd0;
      rd(4, 'hD, "R3 tx empty");
      tick();
      tx_count = 6'd40;
      rd(4, 'h2015, "R4 tx full and trig");
      tick();
      rd(3, 'h41D, "R4 isr bit10");
      wr(3, 32'h1FFF);
      rd(3, 'h415, "R9 level beats clear");
      rx_count = 6'd5; tx_count = 6'd5;
      wr(3, 32'h1FFF);
      rd(3, 0, "R6 clear all");

      // R4 trigger programming
      wr(6, 32'd50);
      rd(6, 50, "R10 tx trig write");
      tx_count = 6'd40;
      rd(4, 'h10, "R4 below trig");
      tx_count = 6'd50;
      rd(4, 'h2000, "R4 at trig");
      wr(6, 32'd32);
      tx_count = 6'd5;
      wr(3, 32'h1FFF);
      rd(3, 0, "R6 clear after trig");

      // R7 events
      ev_rx_overrun = 1;  tick(); clear_events(); rd(3, 'h20,  "R7 overrun");
      ev_frame_err = 1;   tick(); clear_events(); rd(3, 'h60,  "R7 frame");
      ev_parity_err = 1;  tick(); clear_events(); rd(3, 'hE0,  "R7 parity");
      ev_rx_timeout = 1;  tick(); clear_events(); rd(3, 'h1E0, "R7 timeout");
      ev_modem = 1;       tick(); clear_events(); rd(3, 'h3E0, "R7 modem");
      ev_tx_overflow = 1; tick(); clear_events(); rd(3, 'h13E0, "R7 tx overflow");
      wr(3, 32'h1FFF);
      rd(3, 0, "R6 clear events");

      // R9 event versus clear
      ev_parity_err = 1;
      wr(3, 32'h80);
      clear_events();
      rd(3, 'h80, "R9 event beats clear");
      wr(3, 32'h80);
      rd(3, 0, "R6 clear parity");

      // R10 out of range and read-only
      wr(7, 32'hFFFF);
      wr(15, 32'hFFFF);
      wr(4, 32'hFFFF);
      rd(7, 0, "R10 word7 reads zero");
      rd(15, 0, "R10 word15 reads zero");
      rd(4, 0, "R10 status read-only");
      rd(5, 32, "R10 rx trig kept");
      rd(6, 32, "R10 tx trig kept");
      rd(2, 2, "R10 mask kept");
      rd(3, 0, "R10 isr kept");

      // R8 masking
      wr(0, 32'h80);
      ev_parity_err = 1; tick(); clear_events();
      check("R8 enabled pending", int'(irq), 1);
      wr(1, 32'h17FF);
      rd(3, 'h80, "R8 still pending");
      check("R8 masked off", int'(irq), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule